// File: doc/BRIEF.md
# Reflected CRC-8 Byte Checker

This block computes the 8-bit cyclic redundancy check that single-wire bus devices attach to their identifiers and data. Bytes arrive over a valid/ready handshake, one per clock. Each accepted byte folds into a running value with one table-equivalent step: the next value depends only on the running value XOR the incoming byte, under the reflected polynomial x^8+x^5+x^4+1 (constant 0x8C). The step is built as an eight-stage shift/XOR network, so no stored table is needed.

A synchronous clear opens a new frame and sets the running value to 0x00. A byte marked as last closes the frame. On the next cycle the block raises a done flag and, if the running value is zero, a zero flag. If the stream carries the received check byte as its final byte, a good frame therefore ends with zero.

A small controller tracks the frame. It has three states: EMPTY (cleared, no byte taken yet), RUN (at least one byte taken) and CLOSED (the last byte has been taken). Its transitions are: clear from any state goes to EMPTY; an accepted non-last byte goes from EMPTY or RUN to RUN; an accepted last byte goes from EMPTY or RUN to CLOSED. CLOSED holds until the next clear.

Top module: `crc8_byte_checker`

## Requirements
- R1: After reset, crc_out is 0x00, in_ready is 1, frame_done is 0 and crc_zero is 0.
- R2: After a clear, accepting a single byte b makes crc_out equal T[b] on the next cycle. T[i] is produced by shifting i right eight times and XORing 0x8C after each shift that drops a 1.
- R3: Every accepted byte b replaces crc_out with T[crc_out XOR b]. Bytes are applied in arrival order, and a frame may have any length.
- R4: In a cycle with no accepted byte and no clear, crc_out keeps its value.
- R5: While clr is 1, in_ready is 0. A clear sets crc_out to 0x00 on the next cycle, and a byte presented in the same cycle is not absorbed.
- R6: Accepting a byte with in_last=1 makes frame_done 1 on the next cycle. crc_zero is then 1 exactly when crc_out is 0x00.
- R7: While frame_done is 1, in_ready is 0. Bytes presented then leave crc_out unchanged until a clear.
- R8: A frame of seven identifier bytes followed by their own CRC byte ends with crc_zero=1. Corrupting any one bit of such a frame ends it with crc_zero=0.
- R9: The step matches these fixed points: T[0]=0x00, T[1]=0x5E, T[2]=0xBC, T[3]=0xE2, T[128]=0x8C, T[255]=0x35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous frame clear; takes priority over data |
| in_valid | input | 1 | Byte on in_data is offered |
| in_data | input | 8 | Byte to fold into the CRC |
| in_last | input | 1 | Offered byte is the final one of the frame |
| in_ready | output | 1 | Block can take a byte this cycle |
| crc_out | output | 8 | Running CRC value |
| frame_done | output | 1 | Last byte of the frame has been taken |
| crc_zero | output | 1 | Frame closed with a running value of zero |

## Verification
The hardest case to reach from the ports is a good frame: the running value must end at zero, which random bytes hit only about once in 256 frames. The bench builds such frames itself. It computes the check byte of seven identifier bytes with a bit-serial model and appends it, then flips each of the 64 bits in turn to show that every single-bit error is caught. Two more cases need deliberate timing: a clear that coincides with an offered byte, and bytes offered after the frame has closed. The bench drives both on purpose and confirms that crc_out does not move.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
    localparam int unsigned CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

    typedef enum logic [1:0] {
        FR_EMPTY  = 2'd0,
        FR_RUN    = 2'd1,
        FR_CLOSED = 2'd2
    } frame_state_t;
endpackage

// File: rtl/crc8_step.sv
module crc8_step #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] POLY = 8'h8C
) (
    input  logic [W-1:0] idx,
    output logic [W-1:0] res
);
    logic [W-1:0] stage [0:W];

    assign stage[0] = idx;

    for (genvar i = 0; i < W; i++) begin : g_shift
        assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY)
                                        : (stage[i] >> 1);
    end

    assign res = stage[W];
endmodule

// File: rtl/crc8_frame_ctrl.sv
module crc8_frame_ctrl
    import crc8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_valid,
    input  logic in_last,
    output logic in_ready,
    output logic accept,
    output logic frame_done
);
    frame_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = FR_EMPTY;
        end else begin
            unique case (state_q)
                FR_EMPTY, FR_RUN: begin
                    if (in_valid) state_d = in_last ? FR_CLOSED : FR_RUN;
                end
                FR_CLOSED: state_d = FR_CLOSED;
                default:   state_d = FR_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        in_ready   = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            FR_EMPTY, FR_RUN: in_ready   = !clr;
            FR_CLOSED:        frame_done = 1'b1;
            default:          in_ready   = 1'b0;
        endcase
        accept = in_valid && in_ready;
    end

    p_ready_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !in_ready);
    p_closed_noready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !in_ready);
    p_last_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last) |=> frame_done);
endmodule

// File: rtl/crc8_byte_checker.sv
module crc8_byte_checker
    import crc8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [CRC_W-1:0] in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic [CRC_W-1:0] crc_out,
    output logic             frame_done,
    output logic             crc_zero
);
    logic             accept;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] step_res;

    crc8_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .accept     (accept),
        .frame_done (frame_done)
    );

    crc8_step #(.W(CRC_W), .POLY(CRC_POLY_REFL)) u_step (
        .idx (crc_q ^ in_data),
        .res (step_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc_q <= '0;
        else if (clr)    crc_q <= '0;
        else if (accept) crc_q <= step_res;
    end

    assign crc_out  = crc_q;
    assign crc_zero = frame_done && (crc_q == '0);

    p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_out == '0) && !frame_done);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(in_valid && in_ready)) |=> $stable(crc_out));
    p_zero_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_zero |-> frame_done && (crc_out == '0));
endmodule

// File: tb/tb_crc8_byte_checker.sv
module tb_crc8_byte_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] crc_out;
    logic       frame_done;
    logic       crc_zero;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    crc8_byte_checker dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .crc_out(crc_out), .frame_done(frame_done), .crc_zero(crc_zero)
    );

    function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int k = 0; k < 8; k++) begin
            logic mix = r[0] ^ b[k];
            r = r >> 1;
            if (mix) r = r ^ 8'h8C;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input logic last);
        in_valid = 1'b1; in_data = b; in_last = last;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] id [0:7];
        logic [7:0] exp_crc;
        logic [7:0] t;

        @(negedge clk); @(negedge clk);
        // R1 reset values
        check("R1 crc", crc_out, 8'h00);
        check("R1 ready", in_ready, 1);
        check("R1 done", frame_done, 0);
        check("R1 zero", crc_zero, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R6 / R9: exhaustive single-byte sweep
        for (int b = 0; b < 256; b++) begin
            do_clear();
            push(b[7:0], 1'b1);
            t = ref_step(8'h00, b[7:0]);
            check("R2 single", crc_out, t);
            check("R6 done", frame_done, 1);
            check("R6 zero", crc_zero, (t == 8'h00));
            if (b == 0)   check("R9 T0", crc_out, 8'h00);
            if (b == 1)   check("R9 T1", crc_out, 8'h5E);
            if (b == 2)   check("R9 T2", crc_out, 8'hBC);
            if (b == 3)   check("R9 T3", crc_out, 8'hE2);
            if (b == 128) check("R9 T128", crc_out, 8'h8C);
            if (b == 255) check("R9 T255", crc_out, 8'h35);
        end

        // R7 closed frame ignores bytes
        t = crc_out;
        check("R7 ready", in_ready, 0);
        push(8'hA5, 1'b0);
        check("R7 ignored", crc_out, t);

        // R5 clear wins over a simultaneous byte
        do_clear();
        push(8'h37, 1'b0);
        clr = 1'b1; in_valid = 1'b1; in_data = 8'hC3;
        #1 check("R5 ready low", in_ready, 0);
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        check("R5 cleared", crc_out, 8'h00);
        check("R5 not done", frame_done, 0);

        // R3 multi-byte with idle gaps (R4)
        exp_crc = 8'h00;
        for (int n = 0; n < 20; n++) begin
            logic [7:0] v = 8'(n * 37 + 11);
            push(v, 1'b0);
            exp_crc = ref_step(exp_crc, v);
            check("R3 running", crc_out, exp_crc);
            if (n % 5 == 0) begin
                @(negedge clk); @(negedge clk);
                check("R4 hold", crc_out, exp_crc);
            end
        end

        // R8 good identifier and every single-bit corruption
        id[0] = 8'h28; id[1] = 8'h61; id[2] = 8'h64; id[3] = 8'h12;
        id[4] = 8'h3C; id[5] = 8'h7E; id[6] = 8'h09;
        exp_crc = 8'h00;
        for (int i = 0; i < 7; i++) exp_crc = ref_step(exp_crc, id[i]);
        id[7] = exp_crc;
        do_clear();
        for (int i = 0; i < 8; i++) push(id[i], i == 7);
        check("R8 good crc", crc_out, 8'h00);
        check("R8 good zero", crc_zero, 1);
        for (int bit_i = 0; bit_i < 64; bit_i++) begin
            do_clear();
            for (int i = 0; i < 8; i++) begin
                logic [7:0] v = id[i];
                if (i == bit_i / 8) v[bit_i % 8] = ~v[bit_i % 8];
                push(v, i == 7);
            end
            check("R8 corrupt zero", crc_zero, 0);
        end

        finish_run();
    end
endmodule